// File: doc/BRIEF.md
# Dual-Rate LED Dimming Output Stage

This block drives a bank of active-low LED pins. Every pin has its own fast pulse-width modulator, and a 2-bit state code per pin selects one of four modes: off, on, the pin's own modulator alone, or that modulator gated by one slow signal shared by all pins. The shared signal works as a global dimmer at a fixed slow rate, or as a blinker whose period comes from a frequency byte.

A bus-side register file places new duty, state and group settings on the inputs and pulses the update strobe. That logic decides, from its own update-mode setting, whether to pulse at the bus stop condition or at the byte acknowledge. The block copies the inputs into shadow registers on the strobe. It moves them into the active registers only at the end of a fast frame, so no truncated or stretched pulses appear on the pins. Prescaler ratios and the counter width are parameters. With the defaults (8-bit, 5 clocks per step at 125 MHz) the fast frame runs near 97 kHz, dimming runs near 190 Hz, and the blink period spans about 41 ms to about 10.7 s.

Top module: `led_dim_stage`

## Requirements
- R1: With state code 10 and channel duty d, the pin is low for exactly d of every 2^DW fast steps and high for the rest. Each low pulse is d steps long and starts at the frame start. Duty 0 keeps the pin high, and the all-ones duty gives (2^DW-1)/2^DW low.
- R2: State code 00 holds the pin high and state code 01 holds it low, whatever the duty and group settings are.
- R3: With state code 11 the pin is low only when both the channel modulator and the group signal are on. With group duty g, the group signal is on for g of every 2^DW group steps.
- R4: With the blink select at 0, a group step lasts DIM_FRAMES fast frames and the group frequency byte has no effect.
- R5: With the blink select at 1 and frequency byte f, a group step lasts (f+1)*BLINK_UNIT fast frames.
- R6: The pins are active-low. After reset every state code is 00, so all pins are high until the first update strobe. The reset defaults are 0 for the channel duties, all-ones for the group duty, 0 for the frequency byte, and dimming mode.
- R7: While the sleep input is 1, all pins are high from the next clock on and the step prescaler stops. When sleep clears, the programmed pattern resumes.
- R8: The block acts on the setting inputs only through an update-strobe pulse. Changing them without a strobe leaves the pins unchanged.
- R9: Shadowed values reach the active registers only at a fast-frame boundary. Every low pulse therefore has the old width or the new width, never a mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Stops the prescaler and forces all pins high |
| upd_i | input | 1 | One-cycle strobe that captures all setting inputs |
| blink_i | input | 1 | Group mode: 0 dimming, 1 blinking |
| duty_i | input | NUM_CH*DW | Channel duties, channel k at bits [k*DW +: DW] |
| grp_duty_i | input | DW | Group on-fraction |
| grp_freq_i | input | DW | Blink period selector |
| state_i | input | 2*NUM_CH | State codes, channel k at bits [2k+1:2k]: 00 off, 01 on, 10 own PWM, 11 own PWM gated by group |
| led_n_o | output | NUM_CH | Active-low LED pins |

## Verification
A wrong fast phase or a wrongly loaded duty shows up as a low count per frame that differs from the duty. This appears within one frame of 2^DW steps. A wrong group step length or a wrong group comparison changes the low count over one whole group period, so the error shows within that period. A load taken away from the frame boundary appears at once as a low pulse whose width is neither the old duty nor the new one.

// File: rtl/led_dim_pkg.sv
// Shared types for the LED dimming output stage.
// Assumes nothing beyond a 2-bit per-channel mode code.
package led_dim_pkg;
    typedef enum logic [1:0] {
        LS_OFF = 2'b00,
        LS_ON  = 2'b01,
        LS_PWM = 2'b10,
        LS_GRP = 2'b11
    } led_state_e;
endpackage

// File: rtl/led_step_gen.sv
// Step prescaler: emits one fast-PWM step pulse every FAST_DIV clocks.
// Assumes FAST_DIV >= 1. Sleep freezes the count and suppresses steps.
module led_step_gen #(
    parameter int FAST_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic step
);
    localparam int PW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(FAST_DIV - 1);

    logic [PW-1:0] cnt;

    // step pulse when the divider reaches its last count and the clock is awake
    assign step = !sleep && (cnt == LAST);

    // divider count, held while asleep
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (sleep)      cnt <= cnt;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assert_asleep_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(cnt));
endmodule

// File: rtl/led_frame_ctr.sv
// Fast-frame phase counter shared by all channels.
// Advances once per step and flags the last step of each 2^DW-step frame.
module led_frame_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [DW-1:0] phase,
    output logic          frame_end
);
    // frame boundary: final step of the frame
    assign frame_end = step && (&phase);

    // phase count, one increment per step
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (step) phase <= phase + 1'b1;
    end

    assert_phase_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> phase == $past(phase) + 1'b1);
    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(phase));
endmodule

// File: rtl/led_group_gen.sv
// Slow shared group signal. A group step lasts DIM_FRAMES frames when
// dimming, or (freq+1)*BLINK_UNIT frames when blinking. The signal is on
// while the group count is below the group duty.
// Assumes DIM_FRAMES >= 1 and BLINK_UNIT >= 1.
module led_group_gen #(
    parameter int DW         = 8,
    parameter int DIM_FRAMES = 2,
    parameter int BLINK_UNIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_end,
    input  logic          blink,
    input  logic [DW-1:0] gduty,
    input  logic [DW-1:0] gfreq,
    output logic          grp_on
);
    localparam int BLINK_MAX = (1 << DW) * BLINK_UNIT;
    localparam int LIM_MAX   = (BLINK_MAX > DIM_FRAMES) ? BLINK_MAX : DIM_FRAMES;
    localparam int LW        = $clog2(LIM_MAX + 1);

    logic [LW-1:0] limit;
    logic [LW-1:0] fdiv;
    logic [DW-1:0] gcnt;
    logic          gstep;

    // frames per group step for the selected mode
    always_comb begin
        if (blink) limit = ({{(LW-DW){1'b0}}, gfreq} + LW'(1)) * LW'(BLINK_UNIT);
        else       limit = LW'(DIM_FRAMES);
    end

    // group step fires on the frame that completes the current step
    assign gstep = frame_end && (fdiv >= limit - LW'(1));

    // frame divider inside one group step
    always_ff @(posedge clk) begin
        if (!rst_n)         fdiv <= '0;
        else if (gstep)     fdiv <= '0;
        else if (frame_end) fdiv <= fdiv + 1'b1;
    end

    // group phase count
    always_ff @(posedge clk) begin
        if (!rst_n)     gcnt <= '0;
        else if (gstep) gcnt <= gcnt + 1'b1;
    end

    // group on/off level
    assign grp_on = (gcnt < gduty);

    assert_grp_moves_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(gcnt) && $stable(fdiv));
    assert_grp_dim_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !blink && fdiv < LW'(DIM_FRAMES - 1)) |=> $stable(gcnt));
endmodule

// File: rtl/led_channel.sv
// One LED channel: shadow and active copies of its duty and state code,
// and the registered active-low pin. Shadow loads on the update strobe,
// active loads only on a frame boundary.
module led_channel
    import led_dim_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          upd,
    input  logic          load,
    input  logic [DW-1:0] duty_in,
    input  logic [1:0]    state_in,
    input  logic [DW-1:0] phase,
    input  logic          grp_on,
    output logic          led_n
);
    logic [DW-1:0] sh_duty, act_duty;
    led_state_e    sh_state, act_state;
    logic          pwm_on;

    // shadow capture on the update strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_duty  <= '0;
            sh_state <= LS_OFF;
        end else if (upd) begin
            sh_duty  <= duty_in;
            sh_state <= led_state_e'(state_in);
        end
    end

    // active copy moves only at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty  <= '0;
            act_state <= LS_OFF;
        end else if (load) begin
            act_duty  <= sh_duty;
            act_state <= sh_state;
        end
    end

    // channel modulator level
    assign pwm_on = (phase < act_duty);

    // registered pin, low means lit
    always_ff @(posedge clk) begin
        if (!rst_n)     led_n <= 1'b1;
        else if (sleep) led_n <= 1'b1;
        else begin
            case (act_state)
                LS_OFF:  led_n <= 1'b1;
                LS_ON:   led_n <= 1'b0;
                LS_PWM:  led_n <= !pwm_on;
                default: led_n <= !(pwm_on && grp_on);
            endcase
        end
    end

    assert_no_runt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_duty) && $stable(act_state));
    assert_off_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == LS_OFF) |=> led_n);
    assert_on_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == LS_ON && !sleep) |=> !led_n);
    assert_zero_duty_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == LS_PWM && act_duty == '0) |=> led_n);
endmodule

// File: rtl/led_dim_stage.sv
// Top of the dual-rate LED dimming stage. Holds the shadow and active group
// settings and ties the prescaler, frame counter, group generator and the
// per-channel output stages together.
// Assumes upd_i is a single-cycle pulse raised by the bus-side logic.
module led_dim_stage
    import led_dim_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int DW         = 8,
    parameter int FAST_DIV   = 5,
    parameter int DIM_FRAMES = 2,
    parameter int BLINK_UNIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_i,
    input  logic                 upd_i,
    input  logic                 blink_i,
    input  logic [NUM_CH*DW-1:0] duty_i,
    input  logic [DW-1:0]        grp_duty_i,
    input  logic [DW-1:0]        grp_freq_i,
    input  logic [2*NUM_CH-1:0]  state_i,
    output logic [NUM_CH-1:0]    led_n_o
);
    logic          step, frame_end, grp_on;
    logic [DW-1:0] phase;
    logic [DW-1:0] sh_gduty, sh_gfreq, act_gduty, act_gfreq;
    logic          sh_blink, act_blink;

    // group settings shadow, captured on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_gduty <= '1;
            sh_gfreq <= '0;
            sh_blink <= 1'b0;
        end else if (upd_i) begin
            sh_gduty <= grp_duty_i;
            sh_gfreq <= grp_freq_i;
            sh_blink <= blink_i;
        end
    end

    // group settings active copy, moved at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_gduty <= '1;
            act_gfreq <= '0;
            act_blink <= 1'b0;
        end else if (frame_end) begin
            act_gduty <= sh_gduty;
            act_gfreq <= sh_gfreq;
            act_blink <= sh_blink;
        end
    end

    led_step_gen #(.FAST_DIV(FAST_DIV)) u_step (
        .clk(clk), .rst_n(rst_n), .sleep(sleep_i), .step(step)
    );

    led_frame_ctr #(.DW(DW)) u_frame (
        .clk(clk), .rst_n(rst_n), .step(step), .phase(phase), .frame_end(frame_end)
    );

    led_group_gen #(.DW(DW), .DIM_FRAMES(DIM_FRAMES), .BLINK_UNIT(BLINK_UNIT)) u_group (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .blink(act_blink),
        .gduty(act_gduty), .gfreq(act_gfreq), .grp_on(grp_on)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        led_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n), .sleep(sleep_i), .upd(upd_i), .load(frame_end),
            .duty_in(duty_i[k*DW +: DW]), .state_in(state_i[2*k +: 2]),
            .phase(phase), .grp_on(grp_on), .led_n(led_n_o[k])
        );
    end

    assert_sleep_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (&led_n_o));
    assert_grp_load_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(act_gduty) && $stable(act_gfreq) && $stable(act_blink));
endmodule

// File: tb/led_dim_stage_bench.sv
module led_dim_stage_bench;
    localparam int NCH = 8;
    localparam int DW  = 4;
    localparam int FR  = 1 << DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0, upd_i = 1'b0, blink_i = 1'b0;
    logic [NCH*DW-1:0] duty_i = '0;
    logic [DW-1:0] grp_duty_i = '0, grp_freq_i = '0;
    logic [2*NCH-1:0] state_i = '0;
    logic [NCH-1:0] led_n_o;

    int checks = 0;
    int errors = 0;
    int lows [NCH];

    always #4 clk = ~clk;

    led_dim_stage #(.NUM_CH(NCH), .DW(DW), .FAST_DIV(1), .DIM_FRAMES(2), .BLINK_UNIT(1)) u_led_dim_stage (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .upd_i(upd_i), .blink_i(blink_i),
        .duty_i(duty_i), .grp_duty_i(grp_duty_i), .grp_freq_i(grp_freq_i),
        .state_i(state_i), .led_n_o(led_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] mk_duty(input int s);
        logic [NCH*DW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*DW +: DW] = DW'((s + 3*k) % FR);
        return v;
    endfunction

    task automatic configure(input logic [2*NCH-1:0] st, input logic [NCH*DW-1:0] du,
                             input int g, input int f, input logic bl);
        @(negedge clk);
        state_i = st; duty_i = du; grp_duty_i = DW'(g); grp_freq_i = DW'(f); blink_i = bl;
        upd_i = 1'b1;
        @(negedge clk);
        upd_i = 1'b0;
    endtask

    task automatic measure(input int w);
        for (int k = 0; k < NCH; k++) lows[k] = 0;
        repeat (w) begin
            @(negedge clk);
            for (int k = 0; k < NCH; k++) if (!led_n_o[k]) lows[k]++;
        end
    endtask

    // expected low counts over w cycles, w a multiple of the group period
    task automatic verify(input logic [2*NCH-1:0] st, input logic [NCH*DW-1:0] du,
                          input int g, input int w, input string grp_tag);
        for (int k = 0; k < NCH; k++) begin
            int d = int'(du[k*DW +: DW]);
            int e;
            string tag;
            case (st[2*k +: 2])
                2'b00:   begin e = 0; tag = "R2 off"; end
                2'b01:   begin e = w; tag = "R2 on"; end
                2'b10:   begin e = d * w / FR; tag = "R1"; end
                default: begin e = g * d * w / (FR * FR); tag = grp_tag; end
            endcase
            check($sformatf("%s ch%0d d=%0d g=%0d", tag, k, d, g), lows[k], e);
        end
    endtask

    localparam logic [2*NCH-1:0] MIX = 16'hFFA4;
    localparam logic [2*NCH-1:0] ALLPWM = 16'hAAAA;

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH*DW-1:0] du;
        repeat (4) @(negedge clk);
        check("R6 pins high in reset", int'(led_n_o), (1 << NCH) - 1);
        rst_n = 1'b1;
        // R6 and R8: inputs set without a strobe leave every pin dark
        state_i = 16'h5555; duty_i = mk_duty(5); grp_duty_i = '1;
        measure(64);
        for (int k = 0; k < NCH; k++) check($sformatf("R6 R8 no strobe ch%0d", k), lows[k], 0);

        // R1 R2: own PWM sweep over every duty, dimming mode
        for (int s = 0; s < FR; s++) begin
            du = mk_duty(s);
            configure(MIX, du, 15, 0, 1'b0);
            repeat (300) @(negedge clk);
            measure(512);
            verify(MIX, du, 15, 512, "R3 R4");
        end

        // R3 R4: group duty sweep, frequency byte varied and ignored
        for (int g = 0; g < FR; g++) begin
            du = mk_duty(g + 5);
            configure(MIX, du, g, FR - 1 - g, 1'b0);
            repeat (300) @(negedge clk);
            measure(512);
            verify(MIX, du, g, 512, "R3 R4");
        end

        // R5: blink periods
        for (int i = 0; i < 4; i++) begin
            int f = (1 << i) * 2 - 1 - (i == 0 ? 1 : 0);
            int g = (i * 5 + 7) % FR;
            int w = FR * FR * (f + 1);
            du = mk_duty(i + 2);
            configure(MIX, du, g, f, 1'b1);
            repeat (300) @(negedge clk);
            measure(w);
            verify(MIX, du, g, w, "R3 R5");
        end

        // R8: change inputs with no strobe, pattern keeps the strobed values
        du = mk_duty(9);
        configure(MIX, du, 11, 0, 1'b0);
        repeat (300) @(negedge clk);
        duty_i = mk_duty(2); grp_duty_i = 4'd3; state_i = 16'h5555;
        measure(512);
        verify(MIX, du, 11, 512, "R8");

        // R7: sleep darkens all pins, then the pattern resumes
        @(negedge clk);
        sleep_i = 1'b1;
        @(negedge clk);
        measure(100);
        for (int k = 0; k < NCH; k++) check($sformatf("R7 asleep ch%0d", k), lows[k], 0);
        sleep_i = 1'b0;
        repeat (40) @(negedge clk);
        measure(512);
        verify(MIX, du, 11, 512, "R7");

        // R9: strobe at every frame phase, low pulses are old or new width only
        for (int p = 0; p < FR; p++) begin
            int runlen, last, bad;
            logic prev, cur;
            configure(ALLPWM, {NCH{4'd4}}, 15, 0, 1'b0);
            repeat (40) @(negedge clk);
            prev = 1'b1;
            do begin
                @(negedge clk);
                cur = led_n_o[0];
                if (prev && !cur) break;
                prev = cur;
            end while (1);
            runlen = 1; prev = 1'b0; last = 0; bad = 0;
            for (int i = 0; i < 5 * FR; i++) begin
                @(negedge clk);
                if (i == p) begin
                    duty_i[DW-1:0] = 4'd12;
                    upd_i = 1'b1;
                end else upd_i = 1'b0;
                cur = led_n_o[0];
                if (!cur) runlen = prev ? 1 : runlen + 1;
                else if (!prev) begin
                    if (runlen != 4 && runlen != 12) bad++;
                    last = runlen;
                end
                prev = cur;
            end
            upd_i = 1'b0;
            check($sformatf("R9 odd pulses phase %0d", p), bad, 0);
            check($sformatf("R9 final width phase %0d", p), last, 12);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule